// File: doc/BRIEF.md
# Vectored Interrupt Manager

This block collects interrupt requests from up to 96 channels, records each one in a pending flag, and presents the most urgent pending, enabled channel to a processor on one of two lines: a fast-interrupt line and a normal-interrupt line. Software routes each channel to one of the two lines. Software also enables or disables each channel and acknowledges requests by clearing their flags. All of this goes through a small write-only register port. For the normal line the block also returns a handler address, which it reads from a vector table held in the same register space.

Channel 0 has the highest priority, and priority falls as the channel number rises. The two lowest channels are reserved as permanently enabled fast-interrupt sources. Table word 0 is a fallback entry: the vector output shows it whenever no normal-line channel is being served. A channel that is disabled keeps recording requests, so turning it on later releases a request that is already waiting.

The output stage is a four-state machine named by which lines are asserted: `ST_IDLE` (neither), `ST_IRQ` (normal only), `ST_FIQ` (fast only) and `ST_BOTH`. The next state is chosen every cycle from the two winner flags. Every state can move to every other state: it enters `ST_IRQ` or `ST_BOTH` when a normal-routed channel is live, enters `ST_FIQ` or `ST_BOTH` when a fast-routed channel is live, and falls back to `ST_IDLE` when both winner flags drop. The channel indices and the vector are registered in the same cycle as the state.

Top module: `vim_top`

## Requirements
- R1: After reset both lines are low, both channel indices and the vector output are 0, every table word is 0, only channels 0 and 1 are enabled, and only channels 0 and 1 are routed to the fast line.
- R2: A pending flag is set on a 0-to-1 transition of its request input. A request held high sets the flag once only.
- R3: Writing to byte-free word address 140+k clears the flags of channels 32k+i for each set bit i. If a flag is being set and cleared in the same cycle, the set wins.
- R4: Writing to address 128+k enables channels 32k+i for each set bit i, and writing to address 132+k disables them. Channels 0 and 1 stay enabled whatever is written.
- R5: A disabled channel still latches its flag but drives neither line. The cycle after the enabling write, an already-pending channel asserts its line.
- R6: Writing address 136+k loads the route bits for channels 32k+i, where 1 means fast line and 0 means normal line. Channels 0 and 1 are always fast.
- R7: On each line the lowest-numbered live channel (pending, enabled, routed to that line) wins.
- R8: While the normal line is asserted for channel c, the vector output equals table word c+1 and the index is c. Otherwise the vector output equals word 0 and the index is 0. A fast-routed channel never selects a vector.
- R9: The fast line is asserted with the fast index equal to the winning fast channel. The index is 0 when the line is low.
- R10: The outputs change one clock edge after the state changes that cause them. While the normal line stays on the same channel and the table is not written, the vector holds steady.
- R11: A write to word address w, with w from 0 to NUM_CH, stores the data into table word w.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NUM_CH | Per-channel request inputs, rising edge sensitive |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Word address: 0..NUM_CH table, 128..143 control |
| bus_wdata | input | DATA_W | Write data |
| irq_o | output | 1 | Normal interrupt line |
| fiq_o | output | 1 | Fast interrupt line |
| irq_chan_o | output | clog2(NUM_CH) | Channel being served on the normal line |
| fiq_chan_o | output | clog2(NUM_CH) | Channel being served on the fast line |
| irq_vec_o | output | DATA_W | Handler address for the normal line |

## Verification
The hardest cases to reach from the ports are the races between a flag being set and other state changing in the same cycle. One is a request edge that arrives together with a clear write. Another is a flag that is latched while its channel is disabled and only shows once an enable write lands. The bench drives the request edge and the clear strobe on the same negative edge. It also parks a pulse on a disabled channel, confirms the output stays silent, and then enables that channel. Priority is covered by raising every ordered pair of normal channels together in a reduced 40-channel build, so that pairs span the 32-bit word boundary.

// File: rtl/vim_pkg.sv
package vim_pkg;

    localparam int ADDR_W   = 8;
    localparam int CTRL_BIT = 7;

    typedef enum logic [1:0] {
        GRP_EN_SET   = 2'd0,
        GRP_EN_CLR   = 2'd1,
        GRP_ROUTE    = 2'd2,
        GRP_FLAG_CLR = 2'd3
    } ctrl_grp_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_IRQ  = 2'd1,
        ST_FIQ  = 2'd2,
        ST_BOTH = 2'd3
    } out_state_t;

endpackage

// File: rtl/vim_regs.sv
module vim_regs
    import vim_pkg::*;
#(
    parameter int NUM_CH = 96,
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CH-1:0]    req_i,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [NUM_CH-1:0]    pend_q,
    output logic [NUM_CH-1:0]    en_q,
    output logic [NUM_CH-1:0]    route_q
);

    localparam logic [NUM_CH-1:0] FIXED = NUM_CH'(3);

    logic [NUM_CH-1:0] req_q;
    logic [NUM_CH-1:0] rise;
    logic [NUM_CH-1:0] word_hit;
    logic [NUM_CH-1:0] word_bit;
    logic [NUM_CH-1:0] set_m, clr_m, fclr_m;
    logic [NUM_CH-1:0] pend_nxt, en_nxt, route_nxt;
    logic              ctrl_hit;
    ctrl_grp_t         grp;
    logic [1:0]        wsel;

    assign ctrl_hit = bus_we && bus_addr[CTRL_BIT] && (bus_addr[CTRL_BIT-1:4] == '0);
    assign grp      = ctrl_grp_t'(bus_addr[3:2]);
    assign wsel     = bus_addr[1:0];

    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            word_hit[i] = (wsel == 2'(i / DATA_W));
            word_bit[i] = bus_wdata[i % DATA_W];
        end
    end

    assign rise   = req_i & ~req_q;
    assign set_m  = (ctrl_hit && grp == GRP_EN_SET)   ? (word_hit & word_bit) : '0;
    assign clr_m  = (ctrl_hit && grp == GRP_EN_CLR)   ? (word_hit & word_bit) : '0;
    assign fclr_m = (ctrl_hit && grp == GRP_FLAG_CLR) ? (word_hit & word_bit) : '0;

    always_comb begin
        pend_nxt = (pend_q & ~fclr_m) | rise;
        en_nxt   = ((en_q | set_m) & ~clr_m) | FIXED;
        if (ctrl_hit && grp == GRP_ROUTE)
            route_nxt = (route_q & ~word_hit) | (word_hit & word_bit) | FIXED;
        else
            route_nxt = route_q | FIXED;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q   <= '0;
            pend_q  <= '0;
            en_q    <= FIXED;
            route_q <= FIXED;
        end else begin
            req_q   <= req_i;
            pend_q  <= pend_nxt;
            en_q    <= en_nxt;
            route_q <= route_nxt;
        end
    end

endmodule

// File: rtl/vim_prio.sv
module vim_prio #(
    parameter int N  = 96,
    parameter int IW = 7
) (
    input  logic [N-1:0]  live,
    output logic          hit,
    output logic [IW-1:0] idx
);

    always_comb begin
        hit = |live;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (live[i]) idx = IW'(i);
        end
    end

endmodule

// File: rtl/vim_vtab.sv
module vim_vtab #(
    parameter int DEPTH = 97,
    parameter int DW    = 32,
    parameter int IW    = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < DEPTH; w++) mem[w] <= '0;
        end else if (we && int'(waddr) < DEPTH) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = (int'(raddr) < DEPTH) ? mem[raddr] : '0;

endmodule

// File: rtl/vim_top.sv
module vim_top
    import vim_pkg::*;
#(
    parameter int NUM_CH = 96,
    parameter int DATA_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_CH-1:0]           req_i,
    input  logic                        bus_we,
    input  logic [7:0]                  bus_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic                        irq_o,
    output logic                        fiq_o,
    output logic [$clog2(NUM_CH)-1:0]   irq_chan_o,
    output logic [$clog2(NUM_CH)-1:0]   fiq_chan_o,
    output logic [DATA_W-1:0]           irq_vec_o
);

    localparam int CH_W  = $clog2(NUM_CH);
    localparam int DEPTH = NUM_CH + 1;
    localparam int TI_W  = $clog2(DEPTH);

    logic [NUM_CH-1:0] pend_q, en_q, route_q;
    logic [NUM_CH-1:0] live_irq, live_fiq;
    logic              irq_hit, fiq_hit;
    logic [CH_W-1:0]   irq_idx, fiq_idx;
    logic [TI_W-1:0]   rd_idx;
    logic [DATA_W-1:0] rd_word;
    logic              tbl_we;
    out_state_t        state_q, state_nxt;
    logic [CH_W-1:0]   irq_chan_q, fiq_chan_q;
    logic [DATA_W-1:0] vec_q;

    vim_regs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req_i),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .pend_q    (pend_q),
        .en_q      (en_q),
        .route_q   (route_q)
    );

    assign live_irq = pend_q & en_q & ~route_q;
    assign live_fiq = pend_q & en_q &  route_q;

    vim_prio #(.N(NUM_CH), .IW(CH_W)) u_prio_irq (
        .live (live_irq),
        .hit  (irq_hit),
        .idx  (irq_idx)
    );

    vim_prio #(.N(NUM_CH), .IW(CH_W)) u_prio_fiq (
        .live (live_fiq),
        .hit  (fiq_hit),
        .idx  (fiq_idx)
    );

    assign tbl_we = bus_we && !bus_addr[CTRL_BIT] && (int'(bus_addr) < DEPTH);
    assign rd_idx = irq_hit ? (TI_W'(irq_idx) + TI_W'(1)) : '0;

    vim_vtab #(.DEPTH(DEPTH), .DW(DATA_W), .IW(TI_W)) u_vtab (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tbl_we),
        .waddr (bus_addr[TI_W-1:0]),
        .wdata (bus_wdata),
        .raddr (rd_idx),
        .rdata (rd_word)
    );

    // next-state selection from the two winner flags
    always_comb begin
        unique case ({irq_hit, fiq_hit})
            2'b00: state_nxt = ST_IDLE;
            2'b10: state_nxt = ST_IRQ;
            2'b01: state_nxt = ST_FIQ;
            2'b11: state_nxt = ST_BOTH;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nxt;
    end

    // registered output payload, loaded alongside the state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_chan_q <= '0;
            fiq_chan_q <= '0;
            vec_q      <= '0;
        end else begin
            irq_chan_q <= irq_hit ? irq_idx : '0;
            fiq_chan_q <= fiq_hit ? fiq_idx : '0;
            vec_q      <= rd_word;
        end
    end

    assign irq_o      = (state_q == ST_IRQ) || (state_q == ST_BOTH);
    assign fiq_o      = (state_q == ST_FIQ) || (state_q == ST_BOTH);
    assign irq_chan_o = irq_chan_q;
    assign fiq_chan_o = fiq_chan_q;
    assign irq_vec_o  = vec_q;

endmodule

// File: rtl/vim_checker.sv
module vim_checker #(
    parameter int NUM_CH = 96,
    parameter int DATA_W = 32,
    parameter int CW     = $clog2(NUM_CH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic              irq_o,
    input logic              fiq_o,
    input logic [CW-1:0]     irq_chan_o,
    input logic [CW-1:0]     fiq_chan_o,
    input logic [DATA_W-1:0] irq_vec_o,
    input logic [NUM_CH-1:0] pend_q,
    input logic [NUM_CH-1:0] en_q,
    input logic [NUM_CH-1:0] route_q
);

    logic [NUM_CH-1:0] pend_d, en_d, route_d, below;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_d  <= '0;
            en_d    <= '0;
            route_d <= '0;
        end else begin
            pend_d  <= pend_q;
            en_d    <= en_q;
            route_d <= route_q;
        end
    end

    always_comb below = (NUM_CH'(1) << irq_chan_o) - NUM_CH'(1);

    assert_irq_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (en_d[irq_chan_o] && !route_d[irq_chan_o] && pend_d[irq_chan_o]));

    assert_fiq_routed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o |-> (en_d[fiq_chan_o] && route_d[fiq_chan_o] && pend_d[fiq_chan_o]));

    assert_fixed_fiq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q[1:0] == 2'b11) && (route_q[1:0] == 2'b11));

    assert_idle_index_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> (irq_chan_o == '0));

    assert_prio_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((pend_d & en_d & ~route_d & below) == '0));

    assert_vec_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && $past(irq_o) && (irq_chan_o == $past(irq_chan_o)) && !$past(bus_we))
        |-> $stable(irq_vec_o));

endmodule

bind vim_top vim_checker #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_vim_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (bus_we),
    .irq_o      (irq_o),
    .fiq_o      (fiq_o),
    .irq_chan_o (irq_chan_o),
    .fiq_chan_o (fiq_chan_o),
    .irq_vec_o  (irq_vec_o),
    .pend_q     (pend_q),
    .en_q       (en_q),
    .route_q    (route_q)
);

// File: tb/tb_vim_top.sv
module tb_vim_top;

    localparam int N          = 40;
    localparam int CW         = $clog2(N);
    localparam int CLK_PERIOD = 10;
    localparam int G_SET = 0, G_CLR = 1, G_ROUTE = 2, G_FCLR = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req = '0;
    logic          bus_we = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic          irq_o, fiq_o;
    logic [CW-1:0] irq_chan_o, fiq_chan_o;
    logic [31:0]   irq_vec_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vim_top #(.NUM_CH(N), .DATA_W(32)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .irq_o      (irq_o),
        .fiq_o      (fiq_o),
        .irq_chan_o (irq_chan_o),
        .fiq_chan_o (fiq_chan_o),
        .irq_vec_o  (irq_vec_o)
    );

    function automatic logic [31:0] vexp(int w);
        return 32'hC0DE0000 + 32'(w * 17);
    endfunction

    function automatic logic [7:0] ctl(int grp, int ch);
        return 8'(128 + grp * 4 + ch / 32);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_we = 1'b0;
    endtask

    task automatic wr_ch(input int grp, input int ch);
        wr(ctl(grp, ch), 32'(1) << (ch % 32));
    endtask

    task automatic pulse(input int c);
        req[c] = 1'b1; tick();
        req[c] = 1'b0; tick();
    endtask

    task automatic clear_all();
        wr(ctl(G_FCLR, 0), 32'hFFFF_FFFF);
        wr(ctl(G_FCLR, 32), 32'hFFFF_FFFF);
        tick();
    endtask

    task automatic expect_out(input string tag, input logic i, input int ic,
                              input logic f, input int fc, input logic [31:0] v);
        chk({tag, " irq_o"}, 32'(irq_o), 32'(i));
        chk({tag, " irq_chan"}, 32'(irq_chan_o), 32'(ic));
        chk({tag, " fiq_o"}, 32'(fiq_o), 32'(f));
        chk({tag, " fiq_chan"}, 32'(fiq_chan_o), 32'(fc));
        chk({tag, " vec"}, irq_vec_o, v);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog R10: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state, table zero
        expect_out("R1 reset", 0, 0, 0, 0, 32'h0);

        // R11 load every table word
        for (int w = 0; w <= N; w++) wr(8'(w), vexp(w));
        tick();
        expect_out("R11 idle vector word0", 0, 0, 0, 0, vexp(0));

        // per-channel sweep over normal channels
        for (int c = 2; c < N; c++) begin
            wr_ch(G_SET, c);
            pulse(c);
            expect_out("R8 single irq", 1, c, 0, 0, vexp(c + 1));
            wr_ch(G_FCLR, c); tick();
            expect_out("R3 cleared", 0, 0, 0, 0, vexp(0));
            wr_ch(G_CLR, c);
            pulse(c); tick();
            expect_out("R5 disabled silent", 0, 0, 0, 0, vexp(0));
            wr_ch(G_SET, c); tick();
            expect_out("R5 enable releases pending", 1, c, 0, 0, vexp(c + 1));
            wr_ch(G_FCLR, c);
            wr_ch(G_CLR, c); tick();
        end

        // R4 R6 fixed fast channels ignore disable
        wr(ctl(G_CLR, 0), 32'h3);
        wr(ctl(G_ROUTE, 0), 32'h0);
        pulse(1);
        expect_out("R4 ch1 still enabled fast", 0, 0, 1, 1, vexp(0));
        pulse(0);
        expect_out("R9 ch0 beats ch1", 0, 0, 1, 0, vexp(0));
        clear_all();
        expect_out("R9 fast cleared", 0, 0, 0, 0, vexp(0));

        // R6 route a normal channel to the fast line
        wr(ctl(G_SET, 0), 32'hFFFF_FFFF);
        wr(ctl(G_SET, 32), 32'hFFFF_FFFF);
        wr(ctl(G_ROUTE, 0), 32'h20);
        pulse(5);
        expect_out("R6 ch5 routed fast no vector", 0, 0, 1, 5, vexp(0));
        pulse(7);
        expect_out("R8 fast and normal together", 1, 7, 1, 5, vexp(8));
        clear_all();
        wr(ctl(G_ROUTE, 0), 32'h0);
        tick();

        // R3 set wins over same-cycle clear
        req[9] = 1'b1; bus_we = 1'b1; bus_addr = ctl(G_FCLR, 9); bus_wdata = 32'(1) << 9;
        tick();
        req[9] = 1'b0; bus_we = 1'b0;
        tick();
        expect_out("R3 set beats clear", 1, 9, 0, 0, vexp(10));
        clear_all();

        // R2 level request sets only once
        req[10] = 1'b1; tick(); tick();
        expect_out("R2 rising edge sets", 1, 10, 0, 0, vexp(11));
        wr_ch(G_FCLR, 10); tick();
        expect_out("R2 held level no reset", 0, 0, 0, 0, vexp(0));
        req[10] = 1'b0; tick();

        // R10 hold while a lower-priority request arrives
        pulse(12);
        pulse(30);
        expect_out("R10 hold on winner", 1, 12, 0, 0, vexp(13));
        wr_ch(G_FCLR, 12); tick();
        expect_out("R10 next winner after clear", 1, 30, 0, 0, vexp(31));
        clear_all();

        // R7 every ordered pair of normal channels
        for (int a = 2; a < N - 1; a++) begin
            for (int b = a + 1; b < N; b++) begin
                req[a] = 1'b1; req[b] = 1'b1; tick();
                req[a] = 1'b0; req[b] = 1'b0; tick();
                chk("R7 pair winner", 32'(irq_chan_o), 32'(a));
                chk("R7 pair vector", irq_vec_o, vexp(a + 1));
                clear_all();
            end
        end
        expect_out("R7 end idle", 0, 0, 0, 0, vexp(0));

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule